// File: doc/BRIEF.md
# Ordered Store Buffer

This block sits between a processor's load/store request port and the memory side of a node. Stores are parked in a small buffer and returned to memory later. Loads that find no parked store with their address go straight out ahead of those stores. Loads that do find one are answered from the buffer at once. A two-bit mode input picks how strictly stores leave the buffer. In the strict mode they leave in the order they arrived. In the two relaxed modes a store may overtake an older store to a different address. The loosest mode also lets a load that hits the buffer finish ahead of an earlier load still waiting on memory.

A fence handshake lets software wait for all earlier work to finish. While the fence request is high, no new access is taken. The acknowledge rises only when no store is parked and no load is waiting on memory. Stores count as done once memory takes the write request; no write acknowledge comes back.

Top module: `wbuf_order`

## Requirements
- R1: The buffer holds 8 stores (slots 0..7). A store request is accepted while fewer than 8 are held. With 8 held, `cpu_ready_o` is low for stores, but a load whose address matches no held store is still accepted when no load is outstanding.
- R2: A load that misses the buffer is sent on the memory port as a read (`mem_req_write_o` low) before any older held store is drained.
- R3: A load that hits the buffer is answered on the response port in the cycle after it is accepted, with the data of the youngest held store to that address, and sends no read to memory.
- R4: Mode 0 (strict) and mode 3: held stores drain in exactly the order they were accepted.
- R5: Mode 1 (store-relaxed) and mode 2 (weak): a new store takes the lowest-numbered free slot. A store may drain when no older held store has the same address. Among those that may drain, the lowest-numbered slot goes first.
- R6: In every mode, two stores to the same address reach memory in the order they were accepted.
- R7: While `fence_req_i` is high, `cpu_ready_o` is low. `fence_ack_o` is high only when no store is held and no load awaits memory, and it then rises without further input.
- R8: In modes 0, 1 and 3, a load is not accepted while an earlier load awaits memory. In mode 2, a load that hits the buffer is accepted and answered while an earlier load still awaits memory.
- R9: The mode input takes effect only while the buffer holds no store. A change made while stores are held is ignored until the buffer empties.
- R10: Read data arriving on `mem_rsp_valid_i` appears on the response port one cycle later, with the address of the load it answers.
- R11: After reset the buffer is empty, the mode is 0, no memory request or response is valid, and a load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Ordering mode: 0 strict, 1 store-relaxed, 2 weak, 3 strict |
| fence_req_i | input | 1 | Fence request, held until acknowledged |
| fence_ack_o | output | 1 | All earlier accesses complete |
| cpu_valid_i | input | 1 | Processor request valid |
| cpu_ready_o | output | 1 | Processor request accepted this cycle |
| cpu_write_i | input | 1 | 1 store, 0 load |
| cpu_addr_i | input | AW | Request address |
| cpu_wdata_i | input | DW | Store data |
| rsp_valid_o | output | 1 | Load response valid (one cycle) |
| rsp_addr_o | output | AW | Address of the answered load |
| rsp_data_o | output | DW | Load data |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory takes the request |
| mem_req_write_o | output | 1 | 1 write, 0 read |
| mem_req_addr_o | output | AW | Memory request address |
| mem_req_data_o | output | DW | Memory write data |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_data_i | input | DW | Returned read data |

## Verification
A corrupt age relation shows up on the very next drain. Stores leave in the wrong order, or a same-address pair swaps, and the memory write log reveals it at that handshake. A stale slot valid bit shows up either as a forwarded load returning old data one cycle after acceptance, or as a fence that never acknowledges. A wrongly latched mode changes the drain order of the first pair of stores that would differ between modes. The bench holds the memory port closed, fills the buffer, and then opens the port a cycle at a time so that each such fault is visible at a known handshake.

// File: rtl/wbo_pkg.sv
package wbo_pkg;

    typedef enum logic [1:0] {
        ORD_STRICT = 2'd0,
        ORD_STORE  = 2'd1,
        ORD_WEAK   = 2'd2,
        ORD_SPARE  = 2'd3
    } ord_mode_e;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ISSUE = 2'd1,
        RD_WAIT  = 2'd2
    } rd_state_e;

    // store-to-store ordering may be relaxed
    function automatic logic ww_relaxed(ord_mode_e m);
        return (m == ORD_STORE) || (m == ORD_WEAK);
    endfunction

    // load-to-load ordering may be relaxed
    function automatic logic rr_relaxed(ord_mode_e m);
        return m == ORD_WEAK;
    endfunction

endpackage

// File: rtl/wbo_store.sv
module wbo_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_en,
    input  logic [IW-1:0]              alloc_idx,
    input  logic [AW-1:0]              alloc_addr,
    input  logic [DW-1:0]              alloc_data,
    input  logic                       free_en,
    input  logic [IW-1:0]              free_idx,
    input  logic [AW-1:0]              look_addr,
    output logic [DEPTH-1:0]           vld_o,
    output logic [DEPTH-1:0][AW-1:0]   addr_o,
    output logic [DEPTH-1:0][DW-1:0]   data_o,
    output logic [DEPTH-1:0]           hit_o,
    output logic                       full_o,
    output logic [IW-1:0]              free_slot_o
);

    logic [DEPTH-1:0]          vld_q;
    logic [DEPTH-1:0][AW-1:0]  addr_q;
    logic [DEPTH-1:0][DW-1:0]  data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_en && alloc_idx == IW'(i))
                    vld_q[i] <= 1'b1;
                else if (free_en && free_idx == IW'(i))
                    vld_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_en && alloc_idx == IW'(i)) begin
                addr_q[i] <= alloc_addr;
                data_q[i] <= alloc_data;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_o[g] = vld_q[g] && (addr_q[g] == look_addr);
    end

    always_comb begin
        full_o      = &vld_q;
        free_slot_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_slot_o = IW'(i);
        end
    end

    assign vld_o  = vld_q;
    assign addr_o = addr_q;
    assign data_o = data_q;

endmodule

// File: rtl/wbo_age.sv
module wbo_age #(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          alloc_en,
    input  logic [IW-1:0]                 alloc_idx,
    input  logic [DEPTH-1:0]              vld,
    // older_o[a][b] set: slot a was written before slot b
    output logic [DEPTH-1:0][DEPTH-1:0]   older_o
);

    logic [DEPTH-1:0][DEPTH-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else if (alloc_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                older_q[j][alloc_idx] <= vld[j];
                older_q[alloc_idx][j] <= 1'b0;
            end
        end
    end

    assign older_o = older_q;

endmodule

// File: rtl/wbo_pick.sv
module wbo_pick #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]              vld,
    input  logic [DEPTH-1:0][DEPTH-1:0]   older,
    input  logic [DEPTH-1:0][AW-1:0]      addr,
    input  logic [DEPTH-1:0]              hit,
    input  logic                          ww_free,
    output logic                          drain_vld_o,
    output logic [IW-1:0]                 drain_idx_o,
    output logic                          fwd_hit_o,
    output logic [IW-1:0]                 fwd_idx_o
);

    logic [DEPTH-1:0] has_older;
    logic [DEPTH-1:0] has_older_same;
    logic [DEPTH-1:0] has_younger_hit;
    logic [DEPTH-1:0] drain_cand;
    logic [DEPTH-1:0] fwd_cand;

    for (genvar g = 0; g < DEPTH; g++) begin : g_rel
        always_comb begin
            has_older[g]       = 1'b0;
            has_older_same[g]  = 1'b0;
            has_younger_hit[g] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (vld[j] && older[j][g]) begin
                    has_older[g] = 1'b1;
                    if (addr[j] == addr[g]) has_older_same[g] = 1'b1;
                end
                if (hit[j] && older[g][j]) has_younger_hit[g] = 1'b1;
            end
        end
    end

    assign drain_cand = ww_free ? (vld & ~has_older_same) : (vld & ~has_older);
    assign fwd_cand   = hit & ~has_younger_hit;

    always_comb begin
        drain_idx_o = '0;
        fwd_idx_o   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (drain_cand[i]) drain_idx_o = IW'(i);
            if (fwd_cand[i])   fwd_idx_o   = IW'(i);
        end
    end

    assign drain_vld_o = |drain_cand;
    assign fwd_hit_o   = |fwd_cand;

endmodule

// File: rtl/wbo_rd_ctl.sv
module wbo_rd_ctl
    import wbo_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [AW-1:0]  start_addr,
    input  logic           req_taken,
    input  logic           rsp_in,
    output rd_state_e      state_o,
    output logic [AW-1:0]  pend_addr_o
);

    rd_state_e     state_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                RD_IDLE: if (start) begin
                    state_q <= RD_ISSUE;
                    addr_q  <= start_addr;
                end
                RD_ISSUE: if (req_taken) state_q <= RD_WAIT;
                RD_WAIT:  if (rsp_in)    state_q <= RD_IDLE;
                default:  state_q <= RD_IDLE;
            endcase
        end
    end

    assign state_o     = state_q;
    assign pend_addr_o = addr_q;

endmodule

// File: rtl/wbuf_order.sv
module wbuf_order
    import wbo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     mode_i,
    input  logic           fence_req_i,
    output logic           fence_ack_o,
    input  logic           cpu_valid_i,
    output logic           cpu_ready_o,
    input  logic           cpu_write_i,
    input  logic [AW-1:0]  cpu_addr_i,
    input  logic [DW-1:0]  cpu_wdata_i,
    output logic           rsp_valid_o,
    output logic [AW-1:0]  rsp_addr_o,
    output logic [DW-1:0]  rsp_data_o,
    output logic           mem_req_valid_o,
    input  logic           mem_req_ready_i,
    output logic           mem_req_write_o,
    output logic [AW-1:0]  mem_req_addr_o,
    output logic [DW-1:0]  mem_req_data_o,
    input  logic           mem_rsp_valid_i,
    input  logic [DW-1:0]  mem_rsp_data_i
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } rsp_t;

    // ---------------- state and wiring ----------------
    ord_mode_e                   mode_q;
    logic [DEPTH-1:0]            valid_q;
    logic [DEPTH-1:0][AW-1:0]    addr_vec;
    logic [DEPTH-1:0][DW-1:0]    data_vec;
    logic [DEPTH-1:0]            hit_vec;
    logic [DEPTH-1:0][DEPTH-1:0] older_q;
    logic                        full;
    logic [IW-1:0]               free_slot;
    logic                        drain_vld;
    logic [IW-1:0]               drain_idx;
    logic                        any_hit;
    logic [IW-1:0]               fwd_idx;
    rd_state_e                   rd_state;
    logic [AW-1:0]               pend_addr;
    rsp_t                        rsp_q;

    logic ww_free, rr_free, empty;
    logic rd_busy, rd_issue, rd_wait;
    logic wr_ok, rd_ok;
    logic cpu_fire, wr_fire, rd_hit_fire, rd_miss_fire;
    logic mem_fire, rd_req_taken, drain_fire;

    assign empty    = ~|valid_q;
    assign ww_free  = ww_relaxed(mode_q);
    assign rr_free  = rr_relaxed(mode_q);
    assign rd_busy  = rd_state != RD_IDLE;
    assign rd_issue = rd_state == RD_ISSUE;
    assign rd_wait  = rd_state == RD_WAIT;

    // mode is latched only while no store is held
    always_ff @(posedge clk) begin
        if (rst)        mode_q <= ORD_STRICT;
        else if (empty) mode_q <= ord_mode_e'(mode_i);
    end

    // ---------------- processor side ----------------
    assign wr_ok = !full;
    assign rd_ok = any_hit ? ((rr_free || !rd_busy) && !mem_rsp_valid_i) : !rd_busy;

    assign cpu_ready_o  = !fence_req_i && (cpu_write_i ? wr_ok : rd_ok);
    assign cpu_fire     = cpu_valid_i && cpu_ready_o;
    assign wr_fire      = cpu_fire && cpu_write_i;
    assign rd_hit_fire  = cpu_fire && !cpu_write_i && any_hit;
    assign rd_miss_fire = cpu_fire && !cpu_write_i && !any_hit;

    // ---------------- memory side ----------------
    assign mem_req_valid_o = rd_issue || drain_vld;
    assign mem_req_write_o = !rd_issue;
    assign mem_req_addr_o  = rd_issue ? pend_addr : addr_vec[drain_idx];
    assign mem_req_data_o  = rd_issue ? '0 : data_vec[drain_idx];
    assign mem_fire        = mem_req_valid_o && mem_req_ready_i;
    assign rd_req_taken    = mem_fire && rd_issue;
    assign drain_fire      = mem_fire && !rd_issue;

    assign fence_ack_o = fence_req_i && empty && !rd_busy;

    // ---------------- response register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.vld <= 1'b0;
            if (rd_hit_fire) begin
                rsp_q.vld  <= 1'b1;
                rsp_q.addr <= cpu_addr_i;
                rsp_q.data <= data_vec[fwd_idx];
            end else if (rd_wait && mem_rsp_valid_i) begin
                rsp_q.vld  <= 1'b1;
                rsp_q.addr <= pend_addr;
                rsp_q.data <= mem_rsp_data_i;
            end
        end
    end

    assign rsp_valid_o = rsp_q.vld;
    assign rsp_addr_o  = rsp_q.addr;
    assign rsp_data_o  = rsp_q.data;

    // ---------------- sub-blocks ----------------
    wbo_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (wr_fire),
        .alloc_idx   (free_slot),
        .alloc_addr  (cpu_addr_i),
        .alloc_data  (cpu_wdata_i),
        .free_en     (drain_fire),
        .free_idx    (drain_idx),
        .look_addr   (cpu_addr_i),
        .vld_o       (valid_q),
        .addr_o      (addr_vec),
        .data_o      (data_vec),
        .hit_o       (hit_vec),
        .full_o      (full),
        .free_slot_o (free_slot)
    );

    wbo_age #(.DEPTH(DEPTH)) u_age (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (wr_fire),
        .alloc_idx (free_slot),
        .vld       (valid_q),
        .older_o   (older_q)
    );

    wbo_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick (
        .vld         (valid_q),
        .older       (older_q),
        .addr        (addr_vec),
        .hit         (hit_vec),
        .ww_free     (ww_free),
        .drain_vld_o (drain_vld),
        .drain_idx_o (drain_idx),
        .fwd_hit_o   (any_hit),
        .fwd_idx_o   (fwd_idx)
    );

    wbo_rd_ctl #(.AW(AW)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .start       (rd_miss_fire),
        .start_addr  (cpu_addr_i),
        .req_taken   (rd_req_taken),
        .rsp_in      (mem_rsp_valid_i),
        .state_o     (rd_state),
        .pend_addr_o (pend_addr)
    );

endmodule

// File: rtl/wbuf_order_chk.sv
module wbuf_order_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cpu_valid_i,
    input logic                          cpu_write_i,
    input logic                          cpu_ready_o,
    input logic                          fence_ack_o,
    input logic                          mem_req_valid_o,
    input logic                          mem_req_write_o,
    input logic                          mem_req_ready_i,
    input logic                          mem_rsp_valid_i,
    input logic                          rsp_valid_o,
    input logic [DEPTH-1:0]              valid_q,
    input logic [DEPTH-1:0][DEPTH-1:0]   older_q,
    input logic [DEPTH-1:0][AW-1:0]      addr_vec,
    input logic [1:0]                    mode_q,
    input logic [1:0]                    rd_state,
    input logic [IW-1:0]                 drain_idx,
    input logic                          any_hit
);

    logic wr_drain, older_any, older_same, cpu_rd_fire;

    assign wr_drain    = mem_req_valid_o && mem_req_ready_i && mem_req_write_o;
    assign cpu_rd_fire = cpu_valid_i && cpu_ready_o && !cpu_write_i;

    always_comb begin
        older_any  = 1'b0;
        older_same = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (valid_q[j] && older_q[j][drain_idx]) begin
                older_any = 1'b1;
                if (addr_vec[j] == addr_vec[drain_idx]) older_same = 1'b1;
            end
        end
    end

    p_full_stalls_write_r1: assert property (@(posedge clk) disable iff (rst)
        ($countones(valid_q) == DEPTH && cpu_valid_i && cpu_write_i) |-> !cpu_ready_o);

    p_read_goes_first_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_state == 2'd1) |-> (mem_req_valid_o && !mem_req_write_o));

    p_fwd_reply_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd_fire && any_hit) |=> rsp_valid_o);

    p_strict_oldest_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_drain && (mode_q == 2'd0 || mode_q == 2'd3)) |-> !older_any);

    p_same_addr_order_r6: assert property (@(posedge clk) disable iff (rst)
        wr_drain |-> !older_same);

    p_fence_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        fence_ack_o |-> !mem_req_valid_o);

    p_strict_rr_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd_fire && mode_q != 2'd2) |-> (rd_state == 2'd0));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_q != '0) |=> (mode_q == $past(mode_q)));

    p_mem_rsp_fwd_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_state == 2'd2 && mem_rsp_valid_i) |=> rsp_valid_o);

endmodule

bind wbuf_order wbuf_order_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cpu_valid_i     (cpu_valid_i),
    .cpu_write_i     (cpu_write_i),
    .cpu_ready_o     (cpu_ready_o),
    .fence_ack_o     (fence_ack_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_write_o (mem_req_write_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .rsp_valid_o     (rsp_valid_o),
    .valid_q         (valid_q),
    .older_q         (older_q),
    .addr_vec        (addr_vec),
    .mode_q          (mode_q),
    .rd_state        (rd_state),
    .drain_idx       (drain_idx),
    .any_hit         (any_hit)
);

// File: tb/wbuf_order_test.sv
module wbuf_order_test;

    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_i = 2'd0;
    logic          fence_req_i = 1'b0;
    logic          fence_ack_o;
    logic          cpu_valid_i = 1'b0;
    logic          cpu_ready_o;
    logic          cpu_write_i = 1'b0;
    logic [AW-1:0] cpu_addr_i = '0;
    logic [DW-1:0] cpu_wdata_i = '0;
    logic          rsp_valid_o;
    logic [AW-1:0] rsp_addr_o;
    logic [DW-1:0] rsp_data_o;
    logic          mem_req_valid_o;
    logic          mem_req_ready_i = 1'b0;
    logic          mem_req_write_o;
    logic [AW-1:0] mem_req_addr_o;
    logic [DW-1:0] mem_req_data_o;
    logic          mem_rsp_valid_i = 1'b0;
    logic [DW-1:0] mem_rsp_data_i = '0;

    always #5 clk = ~clk;

    wbuf_order #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .fence_req_i(fence_req_i), .fence_ack_o(fence_ack_o),
        .cpu_valid_i(cpu_valid_i), .cpu_ready_o(cpu_ready_o),
        .cpu_write_i(cpu_write_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o), .rsp_data_o(rsp_data_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_req_data_o(mem_req_data_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // memory-side log and response model
    bit            fw [256];
    logic [AW-1:0] fa [256];
    logic [DW-1:0] fd [256];
    int            fn = 0;
    logic [AW-1:0] ra [256];
    logic [DW-1:0] rdat [256];
    int            rn = 0;
    int            rsp_cnt = 0;
    logic [AW-1:0] rsp_addr = '0;
    bit            rsp_hold = 1'b0;

    function automatic logic [DW-1:0] mval(input logic [AW-1:0] a);
        return {16'hD00D, a};
    endfunction

    always begin
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
        if (rsp_cnt > 1) begin
            rsp_cnt--;
        end else if (rsp_cnt == 1 && !rsp_hold) begin
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = mval(rsp_addr);
            rsp_cnt = 0;
        end
        #2;
        if (mem_req_valid_o && mem_req_ready_i && fn < 256) begin
            fw[fn] = mem_req_write_o;
            fa[fn] = mem_req_addr_o;
            fd[fn] = mem_req_data_o;
            fn++;
            if (!mem_req_write_o) begin
                rsp_cnt  = 2;
                rsp_addr = mem_req_addr_o;
            end
        end
        if (rsp_valid_o && rn < 256) begin
            ra[rn]   = rsp_addr_o;
            rdat[rn] = rsp_data_o;
            rn++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_fire(input int idx, input bit wr, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string req);
        logic [48:0] act;
        act = (idx < fn) ? {fw[idx], fa[idx], fd[idx]} : '1;
        chk(idx < fn && fw[idx] == wr && fa[idx] == a && (!wr || fd[idx] == d),
            req, "memory request", longint'(act), longint'({wr, a, wr ? d : fd[idx]}));
    endtask

    task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int t;
        t = 0;
        @(negedge clk);
        cpu_valid_i = 1'b1; cpu_write_i = wr; cpu_addr_i = a; cpu_wdata_i = d;
        #1;
        while (!cpu_ready_o && t < 200) begin
            @(negedge clk); #1; t++;
        end
        @(posedge clk);
        #1 cpu_valid_i = 1'b0;
    endtask

    task automatic cpu_probe(input bit wr, input logic [AW-1:0] a, output bit rdy);
        @(negedge clk);
        cpu_valid_i = 1'b1; cpu_write_i = wr; cpu_addr_i = a; cpu_wdata_i = '0;
        #1 rdy = cpu_ready_o;
        cpu_valid_i = 1'b0;
    endtask

    task automatic drain_one();
        @(negedge clk) mem_req_ready_i = 1'b1;
        @(negedge clk) mem_req_ready_i = 1'b0;
    endtask

    task automatic drain_all();
        @(negedge clk) mem_req_ready_i = 1'b1;
        repeat (14) @(negedge clk);
        mem_req_ready_i = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) mode_i = m;
        repeat (2) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk); #2;
        chk(cpu_ready_o == 1'b1, "R11", "ready after reset", cpu_ready_o, 1);
        chk(mem_req_valid_o == 1'b0, "R11", "mem valid after reset", mem_req_valid_o, 0);
        chk(rsp_valid_o == 1'b0, "R11", "rsp valid after reset", rsp_valid_o, 0);
        chk(fence_ack_o == 1'b0, "R11", "fence ack after reset", fence_ack_o, 0);
    endtask

    // A,B,C queued, one drained, D lands in slot 0, rest drained
    task automatic order_run(input logic [AW-1:0] base, input int exp0, exp1, exp2, exp3,
                             input string req, input bit flip_mode);
        int f0;
        f0 = fn;
        cpu_op(1, base + 0, 32'h100 + 0);
        cpu_op(1, base + 1, 32'h100 + 1);
        cpu_op(1, base + 2, 32'h100 + 2);
        if (flip_mode) begin
            @(negedge clk) mode_i = 2'd0;
        end
        drain_one();
        cpu_op(1, base + 3, 32'h100 + 3);
        drain_all();
        chk(fn - f0 == 4, req, "drain count", fn - f0, 4);
        chk_fire(f0 + 0, 1, base + AW'(exp0), 32'h100 + exp0, req);
        chk_fire(f0 + 1, 1, base + AW'(exp1), 32'h100 + exp1, req);
        chk_fire(f0 + 2, 1, base + AW'(exp2), 32'h100 + exp2, req);
        chk_fire(f0 + 3, 1, base + AW'(exp3), 32'h100 + exp3, req);
    endtask

    task automatic t_strict_order();   // R4
        set_mode(2'd0);
        order_run(16'h0010, 0, 1, 2, 3, "R4", 1'b0);
    endtask

    task automatic t_relaxed_order();  // R5
        set_mode(2'd1);
        order_run(16'h0020, 0, 3, 1, 2, "R5", 1'b0);
    endtask

    task automatic t_mode_hold();      // R9
        set_mode(2'd1);
        order_run(16'h0030, 0, 3, 1, 2, "R9", 1'b1);
        repeat (2) @(negedge clk);
        order_run(16'h0040, 0, 1, 2, 3, "R9", 1'b0);
    endtask

    task automatic t_same_addr();      // R6
        int f0;
        set_mode(2'd1);
        f0 = fn;
        cpu_op(1, 16'h0050, 32'h1);
        cpu_op(1, 16'h0051, 32'h2);
        drain_one();
        cpu_op(1, 16'h0051, 32'h3);
        drain_all();
        chk(fn - f0 == 3, "R6", "drain count", fn - f0, 3);
        chk_fire(f0 + 0, 1, 16'h0050, 32'h1, "R6");
        chk_fire(f0 + 1, 1, 16'h0051, 32'h2, "R6");
        chk_fire(f0 + 2, 1, 16'h0051, 32'h3, "R6");
    endtask

    task automatic t_forward();        // R3
        int f0;
        set_mode(2'd0);
        cpu_op(1, 16'h0060, 32'h600);
        cpu_op(1, 16'h0060, 32'h601);
        cpu_op(1, 16'h0061, 32'h610);
        f0 = fn;
        cpu_op(0, 16'h0060, '0);
        @(negedge clk); #2;
        chk(rsp_valid_o == 1'b1, "R3", "forward valid", rsp_valid_o, 1);
        chk(rsp_addr_o == 16'h0060 && rsp_data_o == 32'h601, "R3", "forward data",
            rsp_data_o, 32'h601);
        drain_all();
        chk(fn - f0 == 3 && fw[f0] && fw[f0+1] && fw[f0+2], "R3", "no memory read",
            fn - f0, 3);
    endtask

    task automatic t_full_bypass();    // R1 R2 R10
        int f0;
        bit rdy;
        set_mode(2'd0);
        for (int i = 0; i < DEPTH; i++) cpu_op(1, 16'h0070 + AW'(i), DW'(i));
        cpu_probe(1, 16'h007F, rdy);
        chk(rdy == 1'b0, "R1", "store ready when full", rdy, 0);
        cpu_probe(0, 16'h0080, rdy);
        chk(rdy == 1'b1, "R1", "miss load ready when full", rdy, 1);
        f0 = fn;
        cpu_op(0, 16'h0080, '0);
        drain_all();
        chk(fn - f0 == 9, "R1", "requests after fill", fn - f0, 9);
        chk_fire(f0, 0, 16'h0080, '0, "R2");
        chk_fire(f0 + 1, 1, 16'h0070, 32'h0, "R2");
        chk_fire(f0 + 8, 1, 16'h0077, 32'h7, "R1");
        chk(rn > 0 && ra[rn-1] == 16'h0080 && rdat[rn-1] == mval(16'h0080), "R10",
            "memory read reply", rdat[rn-1], mval(16'h0080));
    endtask

    task automatic t_fence();          // R7
        bit rdy;
        bit got;
        set_mode(2'd0);
        cpu_op(1, 16'h0090, 32'h9);
        rsp_hold = 1'b1;
        cpu_op(0, 16'h0091, '0);
        @(negedge clk) fence_req_i = 1'b1;
        cpu_probe(1, 16'h0092, rdy);
        chk(rdy == 1'b0, "R7", "ready under fence", rdy, 0);
        @(negedge clk) mem_req_ready_i = 1'b1;
        repeat (6) @(negedge clk);
        #2;
        chk(fence_ack_o == 1'b0, "R7", "ack with read pending", fence_ack_o, 0);
        rsp_hold = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 10 && !got; k++) begin
            @(negedge clk); #2;
            if (fence_ack_o) got = 1'b1;
        end
        chk(got, "R7", "ack after completion", got, 1);
        fence_req_i = 1'b0;
        mem_req_ready_i = 1'b0;
    endtask

    task automatic t_read_order();     // R8 R10
        int r0;
        bit rdy;
        set_mode(2'd2);
        cpu_op(1, 16'h00A0, 32'h77);
        rsp_hold = 1'b1;
        cpu_op(0, 16'h00B0, '0);
        drain_one();
        r0 = rn;
        cpu_op(0, 16'h00A0, '0);
        @(negedge clk); #2;
        chk(rsp_valid_o && rsp_addr_o == 16'h00A0 && rsp_data_o == 32'h77, "R8",
            "weak hit past pending load", rsp_data_o, 32'h77);
        rsp_hold = 1'b0;
        drain_all();
        chk(rn - r0 == 2 && ra[r0+1] == 16'h00B0 && rdat[r0+1] == mval(16'h00B0), "R10",
            "late memory reply", rdat[r0+1], mval(16'h00B0));
        set_mode(2'd0);
        cpu_op(1, 16'h00C0, 32'h88);
        rsp_hold = 1'b1;
        cpu_op(0, 16'h00D0, '0);
        drain_one();
        cpu_probe(0, 16'h00C0, rdy);
        chk(rdy == 1'b0, "R8", "strict hit blocked by pending load", rdy, 0);
        r0 = rn;
        rsp_hold = 1'b0;
        cpu_op(0, 16'h00C0, '0);
        repeat (2) @(negedge clk);
        chk(rn - r0 == 2 && ra[r0] == 16'h00D0 && ra[r0+1] == 16'h00C0, "R8",
            "strict reply order", ra[r0], 16'h00D0);
        drain_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_strict_order();
        t_relaxed_order();
        t_mode_hold();
        t_same_addr();
        t_forward();
        t_full_bypass();
        t_fence();
        t_read_order();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements act=timeout exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule